// File: doc/BRIEF.md
# Attack/Decay Frequency Governor

This block chooses the target clock frequency for one back-end domain of a processor whose domains run on separate clocks. Each cycle in which the domain's clock ticks, it adds the number of valid entries in the domain's issue queue to a running total and counts the cycle. A window ends when a fixed number of instructions has retired. At that point the window's occupancy total and its cycle count are compared with those of the previous window, and the frequency moves in one of four ways:
- It moves by a large step toward more or less speed (attack) when queue pressure has clearly changed.
- It creeps downward (decay) when queue pressure is steady or the queue sat empty.
- It stays where it is when the overall instruction throughput has shifted for reasons outside the domain.
- It takes a large step away from a limit after the setting has stayed at that limit for too long.

The result is an unsigned frequency code in kHz, held between a floor and a ceiling. A one-cycle strobe marks every window's verdict. The frequency steps use a constant multiply and a shift, and the relative thresholds use cross-multiplication, so the block has no divider.

Top module: `dom_freq_governor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `freq_code` equals the ceiling (1000000 kHz by default), `freq_upd` is 0, and all window history is empty.
- R2: A window ends in the cycle where `tick` and `retire` are both high and this is the INTERVAL_INSTR-th such cycle of the window. That cycle's occupancy and the cycle itself belong to the ending window. `freq_upd` is 1 in exactly the following cycle. `freq_code` changes only in a cycle where `freq_upd` is 1.
- R3: A cycle with `tick` low adds nothing to the occupancy total, the cycle count or the retire count, whatever the values of `occ` and `retire`.
- R4: The first window after reset always applies a decay step, because there is no previous window to compare against.
- R5: If 10000·|C−P| > 175·P, where C and P are the current and previous occupancy totals, an attack step is applied. The new value is f + ((f·3932)>>16) when C > P and f − ((f·3932)>>16) when C < P.
- R6: When none of the other rules applies, a decay step f − ((f·115)>>16) is applied. This covers a change at or below the threshold and a window with an occupancy total of 0.
- R7: If a previous window exists and 1000·|Kp−Kc| > 25·Kc, where Kp and Kc are the previous and current window cycle counts (an IPC shift above 2.5 %), the frequency stays unchanged. This rule takes precedence over R5 and R6, including a window with an occupancy total of 0.
- R8: After every step, `freq_code` is clamped to the range 250000 to 1000000 kHz.
- R9: If each of the last 10 consecutive windows ended with the frequency at the floor or at the ceiling, the next window applies an attack step away from that limit, overriding R4 to R7, and the count of such windows restarts from zero. The count also returns to zero whenever a window ends away from both limits.
- R10: `freq_upd` pulses once for every window, including windows where the frequency is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Domain clock tick; gates every count |
| retire | input | 1 | One instruction retired this cycle |
| occ | input | OCC_W | Valid issue-queue entries this cycle |
| freq_code | output | FREQ_W | Target frequency in kHz |
| freq_upd | output | 1 | One-cycle pulse when a window verdict takes effect |

## Verification
The assertions assume that windows are at least two cycles apart, so that successive update strobes never touch. They also assume that a window's cycle count and occupancy total fit in ACC_W bits. The stimulus keeps to both limits: it retires at most one instruction per ticked cycle, spaces retirements with ticked gap cycles, and keeps occupancy below 64. Frequency is measured in kHz throughout, so the step products and threshold cross-products stay well inside 64 bits. The stimulus also inserts cycles with `tick` low and `retire` high, with occupancy at its maximum, to show that such cycles are ignored.

// File: rtl/dfg_pkg.sv
package dfg_pkg;

    typedef enum logic [1:0] {
        VERD_DECAY = 2'd0,
        VERD_UP    = 2'd1,
        VERD_DOWN  = 2'd2,
        VERD_HOLD  = 2'd3
    } verdict_e;

    typedef logic [63:0] wide_t;

    function automatic wide_t span(input wide_t a, input wide_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // true when diff/base > num/den, evaluated without division
    function automatic logic over_ratio(input wide_t diff, input wide_t base,
                                        input wide_t den, input wide_t num);
        return (diff * den) > (base * num);
    endfunction

    function automatic wide_t scale_by(input wide_t v, input wide_t num,
                                       input int unsigned sh);
        wide_t p;
        p = v * num;
        return p >> sh;
    endfunction

    function automatic wide_t clamp_to(input wide_t v, input wide_t lo,
                                       input wide_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/interval_accum.sv
module interval_accum
    import dfg_pkg::*;
#(
    parameter int unsigned OCC_W          = 6,
    parameter int unsigned ACC_W          = 32,
    parameter int unsigned INTERVAL_INSTR = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             retire,
    input  logic [OCC_W-1:0] occ,
    output logic             done,
    output logic [ACC_W-1:0] occ_total,
    output logic [ACC_W-1:0] cyc_total
);
    localparam int unsigned IW = (INTERVAL_INSTR > 2) ? $clog2(INTERVAL_INSTR) : 1;
    localparam logic [IW-1:0] LAST = IW'(INTERVAL_INSTR - 1);

    logic [ACC_W-1:0] acc_q, cyc_q;
    logic [IW-1:0]    icnt_q;

    always_comb begin
        occ_total = acc_q + (tick ? ACC_W'(occ) : '0);
        cyc_total = cyc_q + ACC_W'(tick);
        done      = tick & retire & (icnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            cyc_q  <= '0;
            icnt_q <= '0;
        end else if (done) begin
            acc_q  <= '0;
            cyc_q  <= '0;
            icnt_q <= '0;
        end else if (tick) begin
            acc_q <= occ_total;
            cyc_q <= cyc_total;
            if (retire) icnt_q <= icnt_q + IW'(1);
        end
    end

    // R2
    icnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        icnt_q <= LAST);

    // R3
    untick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (icnt_q == $past(icnt_q)));

endmodule

// File: rtl/change_judge.sv
module change_judge
    import dfg_pkg::*;
#(
    parameter int unsigned ACC_W       = 32,
    parameter int unsigned OCC_THR_NUM = 175,
    parameter int unsigned OCC_THR_DEN = 10000,
    parameter int unsigned IPC_THR_NUM = 25,
    parameter int unsigned IPC_THR_DEN = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [ACC_W-1:0] occ_total,
    input  logic [ACC_W-1:0] cyc_total,
    output verdict_e         verdict
);
    logic [ACC_W-1:0] prev_occ_q, prev_cyc_q;
    logic             hist_q;

    wide_t co, po, cc, pc;
    logic  ipc_shift, occ_shift;

    always_comb begin
        co = wide_t'(occ_total);
        po = wide_t'(prev_occ_q);
        cc = wide_t'(cyc_total);
        pc = wide_t'(prev_cyc_q);
        ipc_shift = over_ratio(span(pc, cc), cc,
                               wide_t'(IPC_THR_DEN), wide_t'(IPC_THR_NUM));
        occ_shift = over_ratio(span(co, po), po,
                               wide_t'(OCC_THR_DEN), wide_t'(OCC_THR_NUM));
        if (!hist_q)
            verdict = VERD_DECAY;
        else if (ipc_shift)
            verdict = VERD_HOLD;
        else if (co == '0)
            verdict = VERD_DECAY;
        else if (occ_shift)
            verdict = (co > po) ? VERD_UP : VERD_DOWN;
        else
            verdict = VERD_DECAY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_occ_q <= '0;
            prev_cyc_q <= '0;
            hist_q     <= 1'b0;
        end else if (done) begin
            prev_occ_q <= occ_total;
            prev_cyc_q <= cyc_total;
            hist_q     <= 1'b1;
        end
    end

    // R6
    idle_no_attack_chk: assert property (@(posedge clk) disable iff (rst)
        (done && occ_total == '0) |-> (verdict != VERD_UP && verdict != VERD_DOWN));

    // R4
    first_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !hist_q) |-> (verdict == VERD_DECAY));

endmodule

// File: rtl/freq_stepper.sv
module freq_stepper
    import dfg_pkg::*;
#(
    parameter int unsigned FREQ_W    = 20,
    parameter int unsigned FREQ_MIN  = 250000,
    parameter int unsigned FREQ_MAX  = 1000000,
    parameter int unsigned ATT_NUM   = 3932,
    parameter int unsigned DEC_NUM   = 115,
    parameter int unsigned STEP_SH   = 16,
    parameter int unsigned EXT_LIMIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  verdict_e          verdict,
    output logic [FREQ_W-1:0] freq_code,
    output logic              freq_upd
);
    localparam int unsigned EW = $clog2(EXT_LIMIT + 1);
    localparam logic [EW-1:0] EXT_TOP = EW'(EXT_LIMIT);

    logic [FREQ_W-1:0] freq_q;
    logic              upd_q;
    logic [EW-1:0]     ext_q, ext_nxt;

    wide_t    f_w, att_w, dec_w, raw_w, next_w;
    verdict_e eff;
    logic     forced, at_max, limit_hit;

    always_comb begin
        f_w    = wide_t'(freq_q);
        att_w  = scale_by(f_w, wide_t'(ATT_NUM), STEP_SH);
        dec_w  = scale_by(f_w, wide_t'(DEC_NUM), STEP_SH);
        forced = (ext_q == EXT_TOP);
        at_max = (f_w == wide_t'(FREQ_MAX));
        eff    = verdict;
        if (forced) eff = at_max ? VERD_DOWN : VERD_UP;
        case (eff)
            VERD_UP:   raw_w = f_w + att_w;
            VERD_DOWN: raw_w = f_w - att_w;
            VERD_HOLD: raw_w = f_w;
            default:   raw_w = f_w - dec_w;
        endcase
        next_w    = clamp_to(raw_w, wide_t'(FREQ_MIN), wide_t'(FREQ_MAX));
        limit_hit = (next_w == wide_t'(FREQ_MIN)) || (next_w == wide_t'(FREQ_MAX));
        if (forced)         ext_nxt = '0;
        else if (limit_hit) ext_nxt = ext_q + EW'(1);
        else                ext_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= FREQ_W'(FREQ_MAX);
            upd_q  <= 1'b0;
            ext_q  <= '0;
        end else begin
            upd_q <= done;
            if (done) begin
                freq_q <= FREQ_W'(next_w);
                ext_q  <= ext_nxt;
            end
        end
    end

    assign freq_code = freq_q;
    assign freq_upd  = upd_q;

    // R8
    freq_range_chk: assert property (@(posedge clk) disable iff (rst)
        (freq_q >= FREQ_W'(FREQ_MIN)) && (freq_q <= FREQ_W'(FREQ_MAX)));

    // R10
    upd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> freq_upd);

    // R2
    upd_single_chk: assert property (@(posedge clk) disable iff (rst)
        freq_upd |=> !freq_upd);

    // R2
    freq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(freq_code));

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && verdict == VERD_HOLD && !forced) |=> $stable(freq_code));

    // R9
    ext_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ext_q <= EXT_TOP);

    // R9
    forced_away_chk: assert property (@(posedge clk) disable iff (rst)
        (done && forced && at_max) |=> (freq_code < $past(freq_code)));

endmodule

// File: rtl/dom_freq_governor.sv
module dom_freq_governor
    import dfg_pkg::*;
#(
    parameter int unsigned OCC_W          = 6,
    parameter int unsigned ACC_W          = 32,
    parameter int unsigned FREQ_W         = 20,
    parameter int unsigned INTERVAL_INSTR = 10000,
    parameter int unsigned FREQ_MIN       = 250000,
    parameter int unsigned FREQ_MAX       = 1000000,
    parameter int unsigned ATT_NUM        = 3932,
    parameter int unsigned DEC_NUM        = 115,
    parameter int unsigned STEP_SH        = 16,
    parameter int unsigned EXT_LIMIT      = 10,
    parameter int unsigned OCC_THR_NUM    = 175,
    parameter int unsigned OCC_THR_DEN    = 10000,
    parameter int unsigned IPC_THR_NUM    = 25,
    parameter int unsigned IPC_THR_DEN    = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              retire,
    input  logic [OCC_W-1:0]  occ,
    output logic [FREQ_W-1:0] freq_code,
    output logic              freq_upd
);
    logic             win_done;
    logic [ACC_W-1:0] win_occ, win_cyc;
    verdict_e         win_verdict;

    interval_accum #(
        .OCC_W(OCC_W), .ACC_W(ACC_W), .INTERVAL_INSTR(INTERVAL_INSTR)
    ) u_accum (
        .clk(clk), .rst(rst), .tick(tick), .retire(retire), .occ(occ),
        .done(win_done), .occ_total(win_occ), .cyc_total(win_cyc)
    );

    change_judge #(
        .ACC_W(ACC_W), .OCC_THR_NUM(OCC_THR_NUM), .OCC_THR_DEN(OCC_THR_DEN),
        .IPC_THR_NUM(IPC_THR_NUM), .IPC_THR_DEN(IPC_THR_DEN)
    ) u_judge (
        .clk(clk), .rst(rst), .done(win_done),
        .occ_total(win_occ), .cyc_total(win_cyc), .verdict(win_verdict)
    );

    freq_stepper #(
        .FREQ_W(FREQ_W), .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX),
        .ATT_NUM(ATT_NUM), .DEC_NUM(DEC_NUM), .STEP_SH(STEP_SH),
        .EXT_LIMIT(EXT_LIMIT)
    ) u_step (
        .clk(clk), .rst(rst), .done(win_done), .verdict(win_verdict),
        .freq_code(freq_code), .freq_upd(freq_upd)
    );

endmodule

// File: tb/tb_dom_freq_governor.sv
module tb_dom_freq_governor;

    localparam int N     = 8;
    localparam longint FMIN = 250000;
    localparam longint FMAX = 1000000;
    localparam int EXT   = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        retire = 1'b0;
    logic [5:0]  occ = '0;
    logic [19:0] freq_code;
    logic        freq_upd;

    always #2 clk = ~clk;

    dom_freq_governor #(.INTERVAL_INSTR(N)) dut (
        .clk(clk), .rst(rst), .tick(tick), .retire(retire), .occ(occ),
        .freq_code(freq_code), .freq_upd(freq_upd)
    );

    int vectors = 0;
    int errors  = 0;
    bit cmp_on  = 1'b0;
    bit finished = 1'b0;

    // reference model state
    longint m_freq = FMAX;
    bit     m_upd = 1'b0;
    longint m_acc = 0, m_cyc = 0, m_po = 0, m_pc = 0;
    int     m_ic = 0, m_ext = 0;
    bit     m_hist = 1'b0;
    string  m_tag = "R2";
    int n_first = 0, n_up = 0, n_down = 0, n_hold = 0, n_zero = 0, n_forced = 0;
    int n_bench_win = 0, n_dut_upd = 0;

    function automatic longint absd(longint a, longint b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic model_eval();
        longint att, dec, nf;
        att = (m_freq * 3932) >>> 16;
        dec = (m_freq * 115) >>> 16;
        if (m_ext == EXT) begin
            nf = (m_freq == FMAX) ? m_freq - att : m_freq + att;
            m_tag = "R9"; n_forced++;
        end else if (!m_hist) begin
            nf = m_freq - dec; m_tag = "R4"; n_first++;
        end else if (1000 * absd(m_pc, m_cyc) > 25 * m_cyc) begin
            nf = m_freq; m_tag = "R7"; n_hold++;
        end else if (m_acc == 0) begin
            nf = m_freq - dec; m_tag = "R6"; n_zero++;
        end else if (10000 * absd(m_acc, m_po) > 175 * m_po) begin
            if (m_acc > m_po) begin nf = m_freq + att; n_up++; end
            else begin nf = m_freq - att; n_down++; end
            m_tag = "R5";
        end else begin
            nf = m_freq - dec; m_tag = "R6";
        end
        if (nf < FMIN) nf = FMIN;
        if (nf > FMAX) nf = FMAX;
        if (m_tag == "R9") m_ext = 0;
        else if (nf == FMIN || nf == FMAX) m_ext++;
        else m_ext = 0;
        m_freq = nf; m_po = m_acc; m_pc = m_cyc; m_hist = 1'b1; m_upd = 1'b1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_freq = FMAX; m_upd = 1'b0; m_acc = 0; m_cyc = 0; m_ic = 0;
            m_ext = 0; m_hist = 1'b0; m_po = 0; m_pc = 0;
        end else begin
            m_upd = 1'b0;
            if (tick) begin
                m_acc += longint'(occ);
                m_cyc += 1;
                if (retire) begin
                    if (m_ic == N - 1) begin
                        model_eval();
                        m_ic = 0; m_acc = 0; m_cyc = 0;
                    end else m_ic++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            vectors++;
            if (longint'(freq_code) != m_freq || freq_upd != m_upd) begin
                errors++;
                $display("FAIL %s: freq=%0d upd=%0b expected freq=%0d upd=%0b",
                         m_tag, freq_code, freq_upd, m_freq, m_upd);
            end
            vectors++;
            if (freq_code < 20'(FMIN) || freq_code > 20'(FMAX)) begin
                errors++;
                $display("FAIL R8: freq=%0d expected within %0d..%0d",
                         freq_code, FMIN, FMAX);
            end
            if (freq_upd) n_dut_upd++;
        end
    end

    task automatic step(input bit t, input bit r, input int o);
        tick = t; retire = r; occ = 6'(o);
        @(negedge clk);
    endtask

    task automatic run_win(input int lvl, input int gap, input bit idle);
        for (int i = 0; i < N; i++) begin
            for (int g = 0; g < gap; g++) step(1'b1, 1'b0, lvl);
            if (idle) step(1'b0, 1'b1, 63); // R3: ignored cycle
            step(1'b1, 1'b1, lvl);
        end
        n_bench_win++;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(freq_code == 20'(FMAX), "R1", int'(freq_code), int'(FMAX));
        check(freq_upd == 1'b0, "R1", int'(freq_upd), 0);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        check(freq_code == 20'(FMAX), "R1", int'(freq_code), int'(FMAX));

        run_win(5, 1, 1'b0);                 // R4 first window
        run_win(5, 1, 1'b0);                 // R6 steady
        for (int l = 20; l <= 57; l++) run_win(l, 1, 1'b0);   // R5 up, R9 at ceiling
        run_win(57, 2, 1'b0);                // R7 throughput shift
        run_win(0, 2, 1'b0);                 // R6 idle queue
        for (int l = 60; l >= 6; l--) run_win(l, 2, 1'b1);    // R5 down, R9 at floor, R3
        run_win(0, 1, 1'b0);                 // R7 hold with empty queue
        for (int k = 0; k < 4; k++) run_win(30, 1, 1'b0);
        step(1'b0, 1'b0, 0);
        step(1'b0, 1'b0, 0);

        check(n_first > 0, "R4", n_first, 1);
        check(n_up > 0, "R5", n_up, 1);
        check(n_down > 0, "R5", n_down, 1);
        check(n_zero > 0, "R6", n_zero, 1);
        check(n_hold > 1, "R7", n_hold, 2);
        check(n_forced > 1, "R9", n_forced, 2);
        check(n_dut_upd == n_bench_win, "R10", n_dut_upd, n_bench_win);
        check(n_dut_upd == n_bench_win, "R3", n_dut_upd, n_bench_win);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule